// File: doc/BRIEF.md
# Two-Operand Leading-One Predictor with Next-Cycle Correction

This block estimates how far the result of adding or subtracting two aligned, unsigned fractions must be shifted left to bring its most significant one to the top. The estimate comes from the two operands alone. It can be formed in the same cycle as the adder that produces the real result, so the normalizing shift does not wait for a count of leading zeros on the sum. The estimate can fall one place short.

Each operand is zero-extended by one bit into a result field of `FRAC_W+1` bits. The first stage builds a per-bit indicator string from the operand bits and priority-encodes it into a predicted shift count and a zero flag, then registers them.

One cycle later the caller supplies the true result from its own adder. The second stage tests the bit that the predicted shift would move to the top. If that bit is zero, the stage selects the alternative candidate, which is the prediction plus one. The second stage registers the corrected shift, which a normalizing left shifter can then use.

Top module: `lop_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `pred_vld_o` and `fix_vld_o` are low.
- R2: `pred_zero_o` is 1 exactly when the true result is zero. That is a==b for subtract (`op_i`=1), and a==0 with b==0 for add (`op_i`=0).
- R3: For add with a nonzero sum, `pred_shift_o` equals the leading-zero count L of the `FRAC_W+1`-bit sum, or L-1.
- R4: For subtract with a>=b and a nonzero difference, `pred_shift_o` equals the leading-zero count L of the `FRAC_W+1`-bit difference, or L-1.
- R5: For add with a nonzero sum, `fix_shift_o` equals the exact leading-zero count of the `FRAC_W+1`-bit sum.
- R6: For subtract with a>=b and a nonzero difference, `fix_shift_o` equals the exact leading-zero count of the difference.
- R7: `pred_vld_o` is high exactly one cycle after `in_vld_i` was high, and `fix_vld_o` exactly one cycle after `pred_vld_o`. A cycle with `in_vld_i` low produces no valid output.
- R8: When the result is zero, `fix_zero_o` is 1 and `fix_shift_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Operands valid this cycle |
| op_i | input | 1 | 0 = add, 1 = subtract (a >= b required) |
| frac_a_i | input | FRAC_W | First aligned fraction (larger one for subtract) |
| frac_b_i | input | FRAC_W | Second aligned fraction |
| res_i | input | FRAC_W+1 | True result of the operands given one cycle earlier |
| pred_vld_o | output | 1 | Prediction valid |
| pred_shift_o | output | $clog2(FRAC_W+1) | Predicted left-shift count |
| pred_zero_o | output | 1 | Predicted zero result |
| fix_vld_o | output | 1 | Corrected shift valid |
| fix_shift_o | output | $clog2(FRAC_W+1) | Corrected left-shift count |
| fix_zero_o | output | 1 | Result is zero |

## Verification
The bench sweeps every pair of 6-bit operands for add, and every ordered pair with a>=b for subtract, streaming one pair per cycle. Along the way it hits the extremes: all-zero operands, equal operands, a carry into the pad bit, and borrows that ripple through long runs of cancelling bits. For each pair the bench computes the sum or difference arithmetically and counts its leading zeros. From that count it can tell an exact prediction from one that is one short, and it tells both apart from a prediction in any other place. Bubbles are inserted between pairs, which makes the valid timing observable.

// File: rtl/lop_pkg.sv
package lop_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } lop_op_e;

    // One bit of the subtract indicator string. Digit at a position is +1 (up),
    // -1 (dn) or 0 (eq). hi = position above, cur = this position, lo = below.
    function automatic logic sub_mark(input logic eq_hi,
                                      input logic up_cur, input logic dn_cur,
                                      input logic up_lo,  input logic dn_lo);
        logic quiet_above;
        quiet_above = eq_hi;
        if (quiet_above)
            return (up_cur & ~dn_lo) | (dn_cur & ~up_lo);
        else
            return (dn_cur & ~dn_lo) | (up_cur & ~up_lo);
    endfunction

    // One bit of the add indicator string: the bit below is not a kill.
    function automatic logic add_mark(input logic a_lo, input logic b_lo);
        return a_lo | b_lo;
    endfunction

endpackage

// File: rtl/lop_indicator.sv
module lop_indicator
    import lop_pkg::*;
#(
    parameter int RES_W = 9
) (
    input  logic [RES_W-1:0] a_i,
    input  logic [RES_W-1:0] b_i,
    input  lop_op_e          op_i,
    output logic [RES_W-1:0] ind_o
);

    // eqx[j]: digit j is zero, j in 1..RES_W (RES_W is the virtual pad above).
    // upx[j]/dnx[j]: digit j-1 is +1 / -1, j in 0..RES_W (index 0 is below bit 0).
    logic [RES_W:1] eqx;
    logic [RES_W:0] upx;
    logic [RES_W:0] dnx;
    logic [RES_W-1:0] sub_f;
    logic [RES_W-1:0] add_f;

    assign eqx[RES_W] = 1'b1;
    assign upx[0]     = 1'b0;
    assign dnx[0]     = 1'b0;

    genvar gj;
    generate
        for (gj = 1; gj < RES_W; gj++) begin : g_eq
            assign eqx[gj] = ~(a_i[gj] ^ b_i[gj]);
        end
        for (gj = 0; gj < RES_W; gj++) begin : g_dig
            assign upx[gj+1] =  a_i[gj] & ~b_i[gj];
            assign dnx[gj+1] = ~a_i[gj] &  b_i[gj];
        end
        for (gj = 0; gj < RES_W; gj++) begin : g_mark
            assign sub_f[gj] = sub_mark(eqx[gj+1], upx[gj+1], dnx[gj+1],
                                        upx[gj], dnx[gj]);
            if (gj == 0) begin : g_add_lsb
                assign add_f[gj] = 1'b0;
            end else begin : g_add_bit
                assign add_f[gj] = add_mark(a_i[gj-1], b_i[gj-1]);
            end
        end
    endgenerate

    assign ind_o = (op_i == OP_SUB) ? sub_f : add_f;

endmodule

// File: rtl/lop_encoder.sv
module lop_encoder #(
    parameter int RES_W = 9,
    parameter int SH_W  = 4
) (
    input  logic [RES_W-1:0] ind_i,
    output logic [SH_W-1:0]  cnt_o,
    output logic             none_o
);

    always_comb begin
        cnt_o = '0;
        for (int k = 0; k < RES_W; k++) begin
            if (ind_i[k]) cnt_o = SH_W'(RES_W - 1 - k);
        end
    end

    assign none_o = ~|ind_i;

endmodule

// File: rtl/lop_correct.sv
module lop_correct #(
    parameter int RES_W = 9,
    parameter int SH_W  = 4
) (
    input  logic [RES_W-1:0] res_i,
    input  logic [SH_W-1:0]  pred_i,
    input  logic             zero_i,
    output logic [SH_W-1:0]  shift_o,
    output logic             zero_o
);

    logic             lead_bit;
    logic [SH_W-1:0]  cand_hi;

    // The bit that a shift by pred_i would bring to the top.
    always_comb begin
        lead_bit = 1'b0;
        for (int k = 0; k < RES_W; k++) begin
            if (pred_i == SH_W'(k)) lead_bit = res_i[RES_W-1-k];
        end
    end

    assign cand_hi = pred_i + SH_W'(1);

    always_comb begin
        if (zero_i)        shift_o = '0;
        else if (lead_bit) shift_o = pred_i;
        else               shift_o = cand_hi;
    end

    assign zero_o = zero_i;

endmodule

// File: rtl/lop_top.sv
module lop_top
    import lop_pkg::*;
#(
    parameter  int FRAC_W = 8,
    localparam int RES_W  = FRAC_W + 1,
    localparam int SH_W   = $clog2(RES_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_vld_i,
    input  logic              op_i,
    input  logic [FRAC_W-1:0] frac_a_i,
    input  logic [FRAC_W-1:0] frac_b_i,
    input  logic [RES_W-1:0]  res_i,
    output logic              pred_vld_o,
    output logic [SH_W-1:0]   pred_shift_o,
    output logic              pred_zero_o,
    output logic              fix_vld_o,
    output logic [SH_W-1:0]   fix_shift_o,
    output logic              fix_zero_o
);

    typedef struct packed {
        logic            vld;
        logic            zero;
        logic [SH_W-1:0] shift;
    } stage_t;

    logic [RES_W-1:0] a_ext;
    logic [RES_W-1:0] b_ext;
    logic [RES_W-1:0] ind;
    logic [SH_W-1:0]  cnt;
    logic             none;
    logic [SH_W-1:0]  fix_shift_d;
    logic             fix_zero_d;
    lop_op_e          op;
    stage_t           pred_q;
    stage_t           fix_q;

    assign a_ext = {1'b0, frac_a_i};
    assign b_ext = {1'b0, frac_b_i};
    assign op    = lop_op_e'(op_i);

    lop_indicator #(.RES_W(RES_W)) u_ind (
        .a_i   (a_ext),
        .b_i   (b_ext),
        .op_i  (op),
        .ind_o (ind)
    );

    lop_encoder #(.RES_W(RES_W), .SH_W(SH_W)) u_enc (
        .ind_i  (ind),
        .cnt_o  (cnt),
        .none_o (none)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pred_q <= '0;
        end else begin
            pred_q.vld   <= in_vld_i;
            pred_q.zero  <= none;
            pred_q.shift <= cnt;
        end
    end

    lop_correct #(.RES_W(RES_W), .SH_W(SH_W)) u_fix (
        .res_i   (res_i),
        .pred_i  (pred_q.shift),
        .zero_i  (pred_q.zero),
        .shift_o (fix_shift_d),
        .zero_o  (fix_zero_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fix_q <= '0;
        end else begin
            fix_q.vld   <= pred_q.vld;
            fix_q.zero  <= fix_zero_d;
            fix_q.shift <= fix_shift_d;
        end
    end

    assign pred_vld_o   = pred_q.vld;
    assign pred_shift_o = pred_q.shift;
    assign pred_zero_o  = pred_q.zero;
    assign fix_vld_o    = fix_q.vld;
    assign fix_shift_o  = fix_q.shift;
    assign fix_zero_o   = fix_q.zero;

endmodule

// File: rtl/lop_checker.sv
module lop_checker #(
    parameter  int FRAC_W = 8,
    localparam int RES_W  = FRAC_W + 1,
    localparam int SH_W   = $clog2(RES_W)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             in_vld_i,
    input logic [RES_W-1:0] res_i,
    input logic             pred_vld_o,
    input logic [SH_W-1:0]  pred_shift_o,
    input logic             fix_vld_o,
    input logic [SH_W-1:0]  fix_shift_o,
    input logic             fix_zero_o
);

    logic [RES_W-1:0] res_q;
    logic             top_after_fix;

    always_ff @(posedge clk_i) begin
        res_q <= res_i;
    end

    always_comb begin
        top_after_fix = 1'b0;
        for (int k = 0; k < RES_W; k++) begin
            if (fix_shift_o == SH_W'(k)) top_after_fix = res_q[RES_W-1-k];
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!pred_vld_o && !fix_vld_o));

    p_pred_follows_in_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        in_vld_i |=> pred_vld_o);

    p_bubble_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_vld_i |=> !pred_vld_o);

    p_fix_follows_pred_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        pred_vld_o |=> fix_vld_o);

    p_zero_shift_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (fix_vld_o && fix_zero_o) |-> (fix_shift_o == '0));

    // R5 / R6: the corrected count is the prediction or the prediction plus one.
    p_fix_candidate_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (fix_vld_o && !fix_zero_o) |->
            (fix_shift_o == $past(pred_shift_o) ||
             fix_shift_o == $past(pred_shift_o) + SH_W'(1)));

    // R6: the corrected shift brings a one to the top of the result.
    p_norm_top_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (fix_vld_o && !fix_zero_o) |-> top_after_fix);

endmodule

bind lop_top lop_checker #(.FRAC_W(FRAC_W)) u_lop_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .in_vld_i     (in_vld_i),
    .res_i        (res_i),
    .pred_vld_o   (pred_vld_o),
    .pred_shift_o (pred_shift_o),
    .fix_vld_o    (fix_vld_o),
    .fix_shift_o  (fix_shift_o),
    .fix_zero_o   (fix_zero_o)
);

// File: tb/test_lop_top.sv
module test_lop_top;

    localparam int FW    = 6;
    localparam int RW    = FW + 1;
    localparam int SW    = $clog2(RW);
    localparam int LIMIT = 200000;

    logic          clk_i = 1'b0;
    logic          rst_i = 1'b1;
    logic          in_vld_i = 1'b0;
    logic          op_i = 1'b0;
    logic [FW-1:0] frac_a_i = '0;
    logic [FW-1:0] frac_b_i = '0;
    logic [RW-1:0] res_i = '0;
    logic          pred_vld_o;
    logic [SW-1:0] pred_shift_o;
    logic          pred_zero_o;
    logic          fix_vld_o;
    logic [SW-1:0] fix_shift_o;
    logic          fix_zero_o;

    int checks = 0;
    int errors = 0;

    // bench pipeline copies: d1 = stage one, d2 = stage two
    bit d1_v = 0, d1_op = 0; int d1_a = 0, d1_b = 0;
    bit d2_v = 0, d2_op = 0; int d2_a = 0, d2_b = 0;

    always #4 clk_i = ~clk_i;

    lop_top #(.FRAC_W(FW)) i_lop_top (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .in_vld_i     (in_vld_i),
        .op_i         (op_i),
        .frac_a_i     (frac_a_i),
        .frac_b_i     (frac_b_i),
        .res_i        (res_i),
        .pred_vld_o   (pred_vld_o),
        .pred_shift_o (pred_shift_o),
        .pred_zero_o  (pred_zero_o),
        .fix_vld_o    (fix_vld_o),
        .fix_shift_o  (fix_shift_o),
        .fix_zero_o   (fix_zero_o)
    );

    function automatic int true_res(bit op, int a, int b);
        return op ? (a - b) : (a + b);
    endfunction

    function automatic int lzc(int x);
        for (int k = RW - 1; k >= 0; k--) begin
            if (x[k]) return RW - 1 - k;
        end
        return RW;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(bit v, bit op, int a, int b);
        int r, lz;
        @(negedge clk_i);
        if (d1_v) begin
            r  = true_res(d1_op, d1_a, d1_b);
            lz = lzc(r);
            chk(pred_vld_o == 1'b1, "R7 pred_vld", int'(pred_vld_o), 1);
            chk(pred_zero_o == (r == 0), "R2 pred_zero", int'(pred_zero_o), int'(r == 0));
            if (r != 0) begin
                if (d1_op)
                    chk(int'(pred_shift_o) == lz || int'(pred_shift_o) == lz - 1,
                        "R4 pred_shift sub", int'(pred_shift_o), lz);
                else
                    chk(int'(pred_shift_o) == lz || int'(pred_shift_o) == lz - 1,
                        "R3 pred_shift add", int'(pred_shift_o), lz);
            end
        end else begin
            chk(pred_vld_o == 1'b0, "R7 pred bubble", int'(pred_vld_o), 0);
        end
        if (d2_v) begin
            r  = true_res(d2_op, d2_a, d2_b);
            lz = lzc(r);
            chk(fix_vld_o == 1'b1, "R7 fix_vld", int'(fix_vld_o), 1);
            if (r == 0) begin
                chk(fix_zero_o == 1'b1, "R8 fix_zero", int'(fix_zero_o), 1);
                chk(fix_shift_o == '0, "R8 fix_shift", int'(fix_shift_o), 0);
            end else begin
                chk(fix_zero_o == 1'b0, "R2 fix_zero", int'(fix_zero_o), 0);
                if (d2_op)
                    chk(int'(fix_shift_o) == lz, "R6 fix_shift sub", int'(fix_shift_o), lz);
                else
                    chk(int'(fix_shift_o) == lz, "R5 fix_shift add", int'(fix_shift_o), lz);
            end
        end else begin
            chk(fix_vld_o == 1'b0, "R7 fix bubble", int'(fix_vld_o), 0);
        end
        d2_v = d1_v; d2_op = d1_op; d2_a = d1_a; d2_b = d1_b;
        d1_v = v;    d1_op = op;    d1_a = a;    d1_b = b;
        in_vld_i = v;
        op_i     = op;
        frac_a_i = FW'(a);
        frac_b_i = FW'(b);
        res_i    = d2_v ? RW'(true_res(d2_op, d2_a, d2_b)) : '0;
    endtask

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        chk(pred_vld_o == 1'b0 && fix_vld_o == 1'b0, "R1 valid during reset",
            int'(pred_vld_o) + int'(fix_vld_o), 0);
        rst_i = 1'b0;
        @(negedge clk_i);
        chk(pred_vld_o == 1'b0 && fix_vld_o == 1'b0, "R1 valid after reset",
            int'(pred_vld_o) + int'(fix_vld_o), 0);
        // R3 R5: every add pair
        for (int a = 0; a < (1 << FW); a++) begin
            for (int b = 0; b < (1 << FW); b++) begin
                if ((a + b) % 7 == 3) step(1'b0, 1'b0, 0, 0);
                step(1'b1, 1'b0, a, b);
            end
        end
        // R4 R6: every subtract pair with a >= b
        for (int a = 0; a < (1 << FW); a++) begin
            for (int b = 0; b <= a; b++) begin
                if ((a ^ b) % 5 == 1) step(1'b0, 1'b1, 0, 0);
                step(1'b1, 1'b1, a, b);
            end
        end
        step(1'b0, 1'b0, 0, 0);
        step(1'b0, 1'b0, 0, 0);
        step(1'b0, 1'b0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", LIMIT, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule